// File: doc/BRIEF.md
# Pattern-Match Push-Button Debouncer

This block cleans up one active-low mechanical push-button line. The raw line first passes through a two-flop synchronizer. It is then sampled once every `TICK_DIV` clock cycles rather than on every edge. Each sample is shifted into a 16-bit history word, with the newest sample entering at bit 0. A pressed sample is 0 and a released sample is 1.

A press is recognised only when the whole history word exactly equals a programmable pattern. For example, the pattern 0xF000 asks for four older released samples followed by twelve pressed ones. On that match the block raises a press pulse for a single clock cycle. In the same cycle it drives the debounced level low.

The level returns high once the history shows a run of released samples as long as the pressed run in the pattern. The length of that run is the number of trailing zero bits in the pattern. Because the pattern needs released samples ahead of the pressed run, a held button cannot match a second time. The debounce time is the sample period multiplied by the run length, and it is chosen by the pattern value.

Top module: `pushbtn_pattern_debounce`

## Requirements
- R1: While reset is asserted and right after it, `press_pulse` is 0 and `btn_level` is 1. Reset loads the history with all ones (released) and clears the sample divider.
- R2: The raw line is synchronized through two flops and sampled once every `TICK_DIV` clock cycles. With 0xF000, no press pulse appears earlier than 11*`TICK_DIV` cycles after the line falls.
- R3: Each sample shifts into history bit 0 and older samples move toward bit 15. With pattern 0x000F (twelve pressed samples, then four released), the pulse appears on the release that follows a long hold, not on the press.
- R4: `press_pulse` is high for exactly one clock cycle when the history, just updated on a sample tick, equals `match_pattern`.
- R5: A button held pressed after a match produces no further press pulses.
- R6: `btn_level` goes to 0 in the same cycle that `press_pulse` is 1.
- R7: `btn_level` returns to 1 on the sample tick at which the newest N samples are all released, where N is the number of trailing zero bits of `match_pattern`. With 0xF000 this takes about 12 sample periods after release.
- R8: The pattern sets the debounce time. With 0xFF00, a press is reported after 8 pressed samples.
- R9: Contact chatter whose pressed runs stay shorter than the pattern's pressed run produces no press pulse and leaves `btn_level` at 1. So does a press held for fewer samples than that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btn_raw_n | input | 1 | Raw push-button line, 0 = pressed |
| match_pattern | input | 16 | History value that declares a press (bit 0 = newest sample) |
| press_pulse | output | 1 | One-cycle press event |
| btn_level | output | 1 | Debounced state, 0 = pressed |

## Verification
The press event and the fall of the debounced level are produced by the same sample tick and must land in the same clock cycle. The bench provokes this with clean presses under two patterns and with a press preceded by chatter. A monitor sampling away from the clock edge flags any pulse cycle in which the level is not already low. The timing windows for the first pulse and for the level's return high confirm that both follow the tick count that the pattern dictates.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  localparam int unsigned HIST_W_DEF = 16;

  typedef enum logic {
    LVL_PRESSED  = 1'b0,
    LVL_RELEASED = 1'b1
  } btn_lvl_e;

endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dbnc_tick.sv
module dbnc_tick #(
  parameter int unsigned DIV = 125000
) (
  input  logic clk,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

  generate
    if (DIV > 1) begin : g_gap_chk
      a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/dbnc_hist.sv
module dbnc_hist
  import dbnc_pkg::*;
#(
  parameter int unsigned W = HIST_W_DEF
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         sample_i,
  input  logic [W-1:0] pattern_i,
  output logic         press_o,
  output logic         level_o
);

  logic [W-1:0] hist_q, hist_d, shifted, rel_mask;
  logic         press_q, press_d;
  btn_lvl_e     level_q, level_d;

  // Mask of the pattern's trailing zero bits: the length of the pressed run.
  always_comb begin
    rel_mask = (pattern_i ^ (pattern_i - W'(1))) >> 1;
  end

  always_comb begin
    shifted = {hist_q[W-2:0], sample_i};
    hist_d  = hist_q;
    press_d = 1'b0;
    level_d = level_q;
    if (tick_i) begin
      hist_d = shifted;
      if (shifted == pattern_i) begin
        press_d = 1'b1;
        level_d = LVL_PRESSED;
      end else if ((shifted & rel_mask) == rel_mask) begin
        level_d = LVL_RELEASED;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '1;
      press_q <= 1'b0;
      level_q <= LVL_RELEASED;
    end else begin
      hist_q  <= hist_d;
      press_q <= press_d;
      level_q <= level_d;
    end
  end

  assign press_o = press_q;
  assign level_o = level_q;

  a_r3_hist_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick_i |=> $stable(hist_q));
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_ni)
    press_q |=> !press_q);
  a_r4_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_ni)
    press_q |-> $past(tick_i));
  a_r6_level_with_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    press_q |-> (level_q == LVL_PRESSED));
  a_r7_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(level_q) |-> $past(tick_i));

endmodule

// File: rtl/pushbtn_pattern_debounce.sv
module pushbtn_pattern_debounce
  import dbnc_pkg::*;
#(
  parameter int unsigned HIST_W   = HIST_W_DEF,
  parameter int unsigned TICK_DIV = 125000,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_raw_n,
  input  logic [HIST_W-1:0] match_pattern,
  output logic              press_pulse,
  output logic              btn_level
);

  logic rst_sync_n;
  logic btn_sync;
  logic tick;

  // Reset: asserted asynchronously, released on a clock edge.
  dbnc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .d_i    (1'b1),
    .q_o    (rst_sync_n)
  );

  dbnc_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_btn_sync (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .d_i    (btn_raw_n),
    .q_o    (btn_sync)
  );

  dbnc_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .tick_o (tick)
  );

  dbnc_hist #(.W(HIST_W)) u_hist (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .tick_i    (tick),
    .sample_i  (btn_sync),
    .pattern_i (match_pattern),
    .press_o   (press_pulse),
    .level_o   (btn_level)
  );

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_sync_n |=> (!press_pulse && btn_level));

endmodule

// File: tb/tb_pushbtn_pattern_debounce.sv
`timescale 1ns/1ps
module tb_pushbtn_pattern_debounce;

  localparam int TD = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        btn_raw_n;
  logic [15:0] match_pattern;
  logic        press_pulse;
  logic        btn_level;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int mark   = 0;
  int pulses = 0;
  int first_pulse = -1;
  int first_rise  = -1;
  int lvl_bad     = 0;
  logic lvl_prev  = 1'b1;

  always #4 clk = ~clk;

  pushbtn_pattern_debounce #(.HIST_W(16), .TICK_DIV(TD)) dut (
    .clk(clk), .rst_n(rst_n), .btn_raw_n(btn_raw_n),
    .match_pattern(match_pattern), .press_pulse(press_pulse),
    .btn_level(btn_level)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (press_pulse) begin
      pulses <= pulses + 1;
      if (first_pulse < 0) first_pulse <= cyc - mark;
      if (btn_level !== 1'b0) lvl_bad <= lvl_bad + 1;
    end
    if (btn_level && !lvl_prev && first_rise < 0) first_rise <= cyc - mark;
    lvl_prev <= btn_level;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic restart(input logic lvl);
    @(posedge clk); #1;
    btn_raw_n   = lvl;
    mark        = cyc;
    pulses      = 0;
    first_pulse = -1;
    first_rise  = -1;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TD) @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; btn_raw_n = 1'b1; match_pattern = 16'hF000;
    repeat (3) @(posedge clk);
    #2;
    chk(press_pulse == 1'b0, "R1 pulse in reset", press_pulse, 0);
    chk(btn_level == 1'b1, "R1 level in reset", btn_level, 1);
    @(posedge clk); #1; rst_n = 1'b1;
    wait_ticks(3);
    chk(btn_level == 1'b1 && press_pulse == 1'b0, "R1 idle after reset", btn_level, 1);
  endtask

  task automatic t_clean_press();
    restart(1'b1); wait_ticks(6);
    restart(1'b0); wait_ticks(20);
    chk(pulses == 1, "R4 one pulse per press", pulses, 1);
    chk(first_pulse >= 11*TD && first_pulse <= 14*TD, "R2 press latency", first_pulse, 12*TD);
    chk(btn_level == 1'b0, "R6 level low while held", btn_level, 0);
    chk(lvl_bad == 0, "R6 level low in pulse cycle", lvl_bad, 0);
    restart(1'b0); wait_ticks(20);
    chk(pulses == 0, "R5 no repeat while held", pulses, 0);
  endtask

  task automatic t_release();
    restart(1'b1); wait_ticks(20);
    chk(first_rise >= 11*TD && first_rise <= 14*TD, "R7 release latency", first_rise, 12*TD);
    chk(pulses == 0, "R7 no pulse on release", pulses, 0);
  endtask

  task automatic t_chatter();
    restart(1'b1);
    for (int t = 0; t < 40; ) begin
      int w = $urandom_range(1, 3);
      btn_raw_n = 1'($urandom_range(0, 1));
      repeat (w) @(posedge clk);
      #1;
      t += w;
    end
    btn_raw_n = 1'b1;
    wait_ticks(20);
    chk(pulses == 0, "R9 chatter gives no pulse", pulses, 0);
    chk(btn_level == 1'b1, "R9 level stays released", btn_level, 1);
    restart(1'b0); wait_ticks(20);
    chk(pulses == 1, "R4 press after chatter", pulses, 1);
    chk(lvl_bad == 0, "R6 level with pulse after chatter", lvl_bad, 0);
    restart(1'b1); wait_ticks(20);
  endtask

  task automatic t_short_press();
    restart(1'b0); wait_ticks(9);
    restart(1'b1); wait_ticks(20);
    chk(pulses == 0, "R9 short press ignored", pulses, 0);
    chk(btn_level == 1'b1, "R9 level after short press", btn_level, 1);
  endtask

  task automatic t_short_pattern();
    match_pattern = 16'hFF00;
    restart(1'b1); wait_ticks(20);
    restart(1'b0); wait_ticks(16);
    chk(pulses == 1, "R8 pulse with 8-sample pattern", pulses, 1);
    chk(first_pulse >= 7*TD && first_pulse <= 10*TD, "R8 shorter latency", first_pulse, 8*TD);
    restart(1'b1); wait_ticks(20);
    chk(btn_level == 1'b1, "R8 level back high", btn_level, 1);
  endtask

  task automatic t_order();
    match_pattern = 16'h000F;
    restart(1'b0); wait_ticks(24);
    chk(pulses == 0, "R3 no pulse on press for 0x000F", pulses, 0);
    restart(1'b1); wait_ticks(10);
    chk(pulses == 1, "R3 pulse on release for 0x000F", pulses, 1);
    chk(first_pulse >= 3*TD && first_pulse <= 6*TD, "R3 release latency", first_pulse, 4*TD);
    match_pattern = 16'hF000;
    wait_ticks(20);
  endtask

  initial begin
    t_reset();
    t_clean_press();
    t_release();
    t_chatter();
    t_short_press();
    t_short_pattern();
    t_order();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule